// File: doc/BRIEF.md
# Symmetric Phase Delay Timer

This block shifts a one-bit squared waveform later in time by a programmable number of sample ticks. A single delay setting gives both the pickup delay and the drop-out delay, so both edges of the waveform are delayed by the same amount. The duty cycle is therefore unchanged. In a phase comparison scheme, the block delays the local square wave so that it lines up with the remote square wave that arrives over the channel. The setting is trimmed on site to the total of the symmetry-adjustment latency, the propagation latency and the receiver latency. Every tick of setting adds one tick to the downstream trip decision time.

The timer advances only on cycles where `tick` is high. The output takes the input's level once the input has disagreed with the output for as many consecutive ticks as the setting. Any disagreement shorter than that is discarded. A setting of zero bypasses the timer and connects the input straight to the output. The setting is captured only while reset is held. A change cannot take effect partway through a timing interval.

Top module: `sym_delay_timer`

## Requirements
- R1: While `rst` is high on a clock edge, the internal count and the held output level are cleared. With a nonzero setting, `sq_out` reads 0 after that edge.
- R2: `dly_set` is captured on every clock edge where `rst` is high and on no other edge. Changing it after reset has no effect on the delay in use.
- R3: With setting N > 0, `sq_out` rises on the Nth consecutive tick edge at which `sq_in` is sampled high while `sq_out` is low.
- R4: With setting N > 0, `sq_out` falls on the Nth consecutive tick edge at which `sq_in` is sampled low while `sq_out` is high.
- R5: A high pulse on `sq_in` that lasts fewer than N ticks leaves `sq_out` low.
- R6: A low gap on `sq_in` that lasts fewer than N ticks leaves `sq_out` high.
- R7: For a waveform whose high and low phases each last at least N ticks, `sq_out` is an exact copy of `sq_in` delayed by N ticks. Its high and low widths equal those of the input.
- R8: With a captured setting of 0 and `rst` low, `sq_out` follows `sq_in` combinationally in the same cycle.
- R9: Clock edges with `tick` low neither advance the count nor change the held output level.
- R10: Reset has priority over a count that would expire on the same edge. The output stays low, and timing restarts from zero after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the setting |
| tick | input | 1 | Sample enable; the timer advances only when high |
| sq_in | input | 1 | Squared input waveform |
| dly_set | input | DLY_W | Delay in sample ticks, applied to both edges |
| sq_out | output | 1 | Delayed waveform |

## Verification
Two events can fall on the same edge: the count reaching the setting, and reset. The bench drives the input high for one tick less than the setting and then raises `rst` for the edge at which the flip would occur. It judges R10 by an output that stays low through that edge and then rises only after a full fresh interval following release. A second collision is the input reverting on exactly the tick that would complete the interval. Pulses of N−1 and N ticks are driven, and only the second may reach the output.

// File: rtl/sym_delay_timer.sv
module sym_delay_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sq_in,
  input  logic [DLY_W-1:0] dly_set,
  output logic             sq_out
);

  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] cnt_q;
  logic             state_q;

  logic [DLY_W-1:0] cnt_nx;
  logic             differ;
  logic             expire;
  logic             bypass;

  assign differ = sq_in ^ state_q;
  assign cnt_nx = cnt_q + 1'b1;
  assign expire = cnt_nx >= dly_q;
  assign bypass = (dly_q == '0) && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q   <= dly_set;
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else if (tick) begin
      if (!differ) begin
        cnt_q <= '0;
      end else if (expire) begin
        state_q <= sq_in;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end

  assign sq_out = bypass ? sq_in : state_q;

endmodule

// File: rtl/sym_delay_timer_chk.sv
module sym_delay_timer_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             sq_in,
  input logic [DLY_W-1:0] dly_q,
  input logic [DLY_W-1:0] cnt_q,
  input logic             state_q
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (state_q == 1'b0 && cnt_q == '0));

  p_setting_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(dly_q));

  p_early_no_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && (sq_in != state_q) && (dly_q != '0) &&
     (({1'b0, cnt_q} + 1'b1) < {1'b0, dly_q})) |=> $stable(state_q));

  p_match_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && (sq_in == state_q)) |=> (cnt_q == '0));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (dly_q != '0) |-> (cnt_q < dly_q));

  p_zero_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (dly_q == '0) |-> (cnt_q == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(state_q) && $stable(cnt_q)));

endmodule

bind sym_delay_timer sym_delay_timer_chk #(.DLY_W(DLY_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .sq_in   (sq_in),
  .dly_q   (dly_q),
  .cnt_q   (cnt_q),
  .state_q (state_q)
);

// File: tb/sym_delay_timer_test.sv
module sym_delay_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       sq_in = 1'b0;
  logic [7:0] dly_set = 8'd0;
  logic       sq_out;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  sym_delay_timer #(.DLY_W(8)) uut (
    .clk(clk), .rst(rst), .tick(tick), .sq_in(sq_in),
    .dly_set(dly_set), .sq_out(sq_out)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: sq_out=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset(input int n, input logic lvl);
    @(negedge clk);
    rst = 1'b1; dly_set = 8'(n); sq_in = lvl; tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic settle_high(input int n);
    sq_in = 1'b1;
    repeat (n + 1) @(negedge clk);
  endtask

  task automatic t_reset_r1();
    do_reset(5, 1'b1);
    chk("R1 output low after reset", sq_out, 1'b0);
  endtask

  task automatic t_rise_r3();
    do_reset(5, 1'b0);
    sq_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 not yet risen at N-1", sq_out, 1'b0);
    @(negedge clk);
    chk("R3 risen at N", sq_out, 1'b1);
  endtask

  task automatic t_fall_r4();
    do_reset(6, 1'b0);
    settle_high(6);
    chk("R4 high before fall", sq_out, 1'b1);
    sq_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 not yet fallen at N-1", sq_out, 1'b1);
    @(negedge clk);
    chk("R4 fallen at N", sq_out, 1'b0);
  endtask

  task automatic t_short_pulse_r5();
    logic seen;
    do_reset(5, 1'b0);
    sq_in = 1'b1;
    repeat (4) @(negedge clk);
    sq_in = 1'b0;
    seen = 1'b0;
    repeat (12) begin
      @(negedge clk);
      seen = seen | sq_out;
    end
    chk("R5 pulse of N-1 ticks absorbed", seen, 1'b0);
    sq_in = 1'b1;
    repeat (5) @(negedge clk);
    sq_in = 1'b0;
    chk("R5 pulse of N ticks passes", sq_out, 1'b1);
  endtask

  task automatic t_short_gap_r6();
    logic low_seen;
    do_reset(4, 1'b0);
    settle_high(4);
    sq_in = 1'b0;
    repeat (3) @(negedge clk);
    sq_in = 1'b1;
    low_seen = 1'b0;
    repeat (10) begin
      @(negedge clk);
      low_seen = low_seen | ~sq_out;
    end
    chk("R6 gap of N-1 ticks absorbed", low_seen, 1'b0);
  endtask

  task automatic t_square_r7();
    logic inp [0:63];
    logic exp_v;
    int   bad;
    do_reset(5, 1'b0);
    repeat (6) @(negedge clk);
    bad = 0;
    for (int c = 0; c < 64; c++) begin
      exp_v = (c >= 5) ? inp[c-5] : 1'b0;
      if (sq_out !== exp_v) bad++;
      inp[c] = ((c % 16) < 7);
      sq_in = inp[c];
      @(negedge clk);
    end
    n_run++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R7 delayed copy: %0d mismatching cycles expected 0", bad);
    end
  endtask

  task automatic t_zero_r8();
    do_reset(0, 1'b0);
    sq_in = 1'b1; #1;
    chk("R8 bypass high same cycle", sq_out, 1'b1);
    sq_in = 1'b0; #1;
    chk("R8 bypass low same cycle", sq_out, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_tick_gate_r9();
    do_reset(2, 1'b0);
    tick = 1'b0;
    sq_in = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 no tick no rise", sq_out, 1'b0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 one tick insufficient", sq_out, 1'b0);
    tick = 1'b1;
    @(negedge clk);
    chk("R9 second tick rises", sq_out, 1'b1);
  endtask

  task automatic t_setting_frozen_r2();
    do_reset(3, 1'b0);
    dly_set = 8'd10;
    sq_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 held setting, not yet", sq_out, 1'b0);
    @(negedge clk);
    chk("R2 held setting 3 used", sq_out, 1'b1);
  endtask

  task automatic t_reset_wins_r10();
    do_reset(4, 1'b0);
    sq_in = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset beats expiry", sq_out, 1'b0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 restart not early", sq_out, 1'b0);
    @(negedge clk);
    chk("R10 restart full interval", sq_out, 1'b1);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_rise_r3();
    t_fall_r4();
    t_short_pulse_r5();
    t_short_gap_r6();
    t_square_r7();
    t_zero_r8();
    t_tick_gate_r9();
    t_setting_frozen_r2();
    t_reset_wins_r10();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule